// File: doc/BRIEF.md
# UART Receive Buffer with Level Interrupt

This block is the receive-side character store of a UART-style peripheral. Characters arrive from the serial receiver, or from a loopback path, as 12-bit entries: 8 data bits and 4 error-status bits. They are held in circular storage and presented at a register read port. A register read returns the oldest entry and loads its error bits into a status register. A separate event input stores a line break as an entry of its own.

The buffer has two modes. The `fifo_en` input selects them. With `fifo_en` high the buffer queues up to `DEPTH` (16) entries. With it low the buffer acts as a single holding register, and all pointer arithmetic wraps modulo 1. When `fifo_en` changes, the contents are discarded. The block drives full and empty flags. It also drives a receive-level interrupt request, which is set when a write brings the occupancy up to the trigger level and cleared when a read leaves the occupancy one below it. The trigger level is fixed at 1.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `empty` is 1 and `full`, `rx_irq`, `overrun` and `rx_status` are all 0. The latched mode is character mode.
- R2: With `fifo_en` high, up to 16 entries are held and read back in the order they were written. `full` becomes 1 on the cycle after the 16th accepted write.
- R3: With `fifo_en` low, one entry is held. `full` becomes 1 after a single accepted write.
- R4: A write offered while no slot is free, after any read in the same cycle, is dropped. The stored contents do not change, and `overrun` is high for exactly one cycle after that edge.
- R5: `rd_data` always shows the entry at the read position. Its layout is bit 11 overrun, bit 10 break, bit 9 parity error, bit 8 framing error, and bits 7:0 data. A read removes that entry and advances the read position.
- R6: A read while the buffer is empty does not change the occupancy or the read position. It leaves `empty` at 1 and `full` at 0.
- R7: Every read loads bits 11:8 of the entry shown on `rd_data` into `rx_status`.
- R8: `rx_irq` is set by a write that brings the occupancy to 1. It is cleared by a read that leaves the occupancy at 0.
- R9: In a cycle where `fifo_en` differs from the latched mode, the buffer is flushed: occupancy and read position go to 0, `empty` to 1 and `full` to 0. Any read or write in that cycle is dropped, and `rx_irq` keeps its value.
- R10: A `brk_evt` pulse with `wr_en` low stores the entry 12'h400 (break bit set, data 0). When `wr_en` is high in the same cycle, only the `wr_en` entry is stored.
- R11: A read and a write in the same cycle act as the read followed by the write. On a full buffer both succeed and no overrun is signalled.
- R12: `full` is 1 exactly when the occupancy equals the effective depth. `empty` is 1 exactly when the occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| wr_en | input | 1 | Store a received character |
| wr_data | input | 8 | Received data byte |
| wr_err | input | 4 | Error bits {overrun, break, parity, framing} |
| brk_evt | input | 1 | Store a break-condition entry |
| rd_en | input | 1 | Data-register read strobe |
| rd_data | output | 12 | Entry at the read position |
| rx_status | output | 4 | Error bits of the last entry read |
| full | output | 1 | Buffer full flag |
| empty | output | 1 | Buffer empty flag |
| rx_irq | output | 1 | Receive-level interrupt request |
| overrun | output | 1 | One-cycle pulse when a write is dropped |

## Verification
A wrong occupancy count shows up at the ports within one cycle. The full or empty flag then disagrees with the number of writes and reads made so far, and the bound checker reports that mismatch on the next edge. A wrong read position or wrong wrap mask is not visible until the affected entry reaches `rd_data`. For that reason the bench fills the buffer completely and drains it, and it also checks a read on an empty buffer followed by a fresh write. Flush errors appear as stale entries after a mode change, so the bench writes and reads new data right after each mode switch.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TRIG  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [3:0]       wr_err,
  input  logic             brk_evt,
  input  logic             rd_en,
  output logic [DW+3:0]    rd_data,
  output logic [3:0]       rx_status,
  output logic             full,
  output logic             empty,
  output logic             rx_irq,
  output logic             overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + 4;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] pos, p_r, mask, slot;
  logic [AW:0]   cnt, c_r, c_n, lim;
  logic          mode_q, flush, rd_go, pop, push, acc;
  logic [EW-1:0] entry;

  assign flush = fifo_en != mode_q;
  assign mask  = mode_q ? AW'(DEPTH - 1) : '0;
  assign lim   = mode_q ? (AW+1)'(DEPTH) : (AW+1)'(1);
  assign rd_go = rd_en & ~flush;
  assign pop   = rd_go & (cnt != 0);
  assign c_r   = pop ? cnt - 1'b1 : cnt;
  assign p_r   = pop ? (pos + 1'b1) & mask : pos;
  assign push  = (wr_en | brk_evt) & ~flush;
  assign acc   = push & (c_r < lim);
  assign c_n   = acc ? c_r + 1'b1 : c_r;
  assign slot  = (p_r + c_r[AW-1:0]) & mask;
  assign entry = wr_en ? {wr_err, wr_data} : {4'b0100, {DW{1'b0}}};
  assign rd_data = mem[pos];

  always_ff @(posedge clk) begin
    if (acc) mem[slot] <= entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      cnt       <= '0;
      pos       <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      rx_irq    <= 1'b0;
      overrun   <= 1'b0;
      rx_status <= '0;
    end else if (flush) begin
      mode_q  <= fifo_en;
      cnt     <= '0;
      pos     <= '0;
      full    <= 1'b0;
      empty   <= 1'b1;
      overrun <= 1'b0;
    end else begin
      cnt     <= c_n;
      pos     <= p_r;
      overrun <= push & ~acc;
      if (rd_go) rx_status <= mem[pos][EW-1:DW];
      if (acc && c_n == lim) full <= 1'b1;
      else if (rd_go)        full <= 1'b0;
      if (acc)                    empty <= 1'b0;
      else if (rd_go && c_r == 0) empty <= 1'b1;
      if (acc && c_n == (AW+1)'(TRIG))            rx_irq <= 1'b1;
      else if (rd_go && c_r + 1'b1 == (AW+1)'(TRIG)) rx_irq <= 1'b0;
    end
  end
endmodule

module uart_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_en,
  input logic        mode_q,
  input logic [AW:0] cnt,
  input logic        full,
  input logic        empty,
  input logic        overrun
);
  logic [AW:0] lim;
  assign lim = mode_q ? (AW+1)'(DEPTH) : (AW+1)'(1);

  a_r12_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);
  a_r12_full_match: assert property (@(posedge clk) disable iff (!rst_n)
    full == (cnt == lim));
  a_r12_empty_match: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (cnt == 0));
  a_r4_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(full));
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != mode_q) |=> (empty && !full));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode_q(mode_q),
  .cnt(cnt), .full(full), .empty(empty), .overrun(overrun)
);

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, fifo_en = 0, wr_en = 0, brk_evt = 0, rd_en = 0;
  logic [7:0]  wr_data = 0;
  logic [3:0]  wr_err = 0;
  logic [11:0] rd_data;
  logic [3:0]  rx_status;
  logic        full, empty, rx_irq, overrun;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_rx_fifo i_uart_rx_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_en(wr_en),
    .wr_data(wr_data), .wr_err(wr_err), .brk_evt(brk_evt), .rd_en(rd_en),
    .rd_data(rd_data), .rx_status(rx_status), .full(full), .empty(empty),
    .rx_irq(rx_irq), .overrun(overrun)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push(logic [7:0] d, logic [3:0] e);
    wr_en = 1; wr_data = d; wr_err = e;
    step();
    wr_en = 0;
  endtask

  task automatic pop(string req, logic [11:0] exp);
    chk(req, rd_data, exp);
    rd_en = 1;
    step();
    rd_en = 0;
    chk("R7", rx_status, exp[11:8]);
  endtask

  task automatic set_mode(logic m);
    fifo_en = m;
    step();
  endtask

  task automatic t_reset();
    chk("R1", empty, 1); chk("R1", full, 0); chk("R1", rx_irq, 0);
    chk("R1", overrun, 0); chk("R1", rx_status, 0);
  endtask

  task automatic t_fifo_order();
    set_mode(1);
    push(8'h03, 4'h0);
    chk("R8", rx_irq, 1);
    chk("R2", empty, 0);
    for (int i = 1; i < 16; i++) begin
      chk("R2", full, 0);
      push(8'(i*7+3), 4'(i));
    end
    chk("R2", full, 1);
    push(8'hEE, 4'h0);
    chk("R4", overrun, 1);
    step();
    chk("R4", overrun, 0);
    for (int i = 0; i < 16; i++) begin
      pop("R5", {4'(i), 8'(i*7+3)});
      chk("R2", full, 0);
      if (i < 15) chk("R8", rx_irq, 1);
    end
    chk("R5", empty, 1);
    chk("R8", rx_irq, 0);
  endtask

  task automatic t_empty_read();
    rd_en = 1; step(); rd_en = 0;
    chk("R6", empty, 1); chk("R6", full, 0);
    push(8'hA5, 4'h2);
    pop("R6", 12'h2A5);
    chk("R6", empty, 1);
  endtask

  task automatic t_char();
    set_mode(0);
    push(8'h41, 4'h1);
    chk("R3", full, 1);
    push(8'h42, 4'h0);
    chk("R4", overrun, 1);
    pop("R3", 12'h141);
    chk("R3", empty, 1);
    chk("R4", overrun, 0);
  endtask

  task automatic t_break();
    brk_evt = 1; step(); brk_evt = 0;
    pop("R10", 12'h400);
    brk_evt = 1; wr_en = 1; wr_data = 8'h5A; wr_err = 4'h0;
    step();
    brk_evt = 0; wr_en = 0;
    chk("R10", overrun, 0);
    pop("R10", 12'h05A);
    chk("R10", empty, 1);
  endtask

  task automatic t_simul();
    push(8'h61, 4'h0);
    chk("R11", full, 1);
    chk("R11", rd_data, 12'h061);
    rd_en = 1; wr_en = 1; wr_data = 8'h62; wr_err = 4'h8;
    step();
    rd_en = 0; wr_en = 0;
    chk("R11", overrun, 0);
    chk("R11", full, 1);
    pop("R11", 12'h862);
  endtask

  task automatic t_flush();
    set_mode(1);
    push(8'h10, 4'h0); push(8'h11, 4'h0); push(8'h12, 4'h0);
    fifo_en = 0; wr_en = 1; wr_data = 8'h77;
    step();
    wr_en = 0;
    chk("R9", empty, 1); chk("R9", full, 0); chk("R9", rx_irq, 1);
    push(8'h20, 4'h0);
    pop("R9", 12'h020);
    chk("R9", empty, 1);
    chk("R8", rx_irq, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fifo_order();
    t_empty_read();
    t_char();
    t_break();
    t_simul();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule